// File: doc/BRIEF.md
# Serial Programming Port Slave

This block is the device side of a two-wire serial programming port. The host drives a slow programming clock on one pin and uses a second, bidirectional pin for data. Both pins are brought into the fast system clock domain through synchronizers, and the block works on the rising and falling edges it detects there. The block assembles 6-bit commands, sent least significant bit first. It then moves 16-cycle data frames in or out, and it turns the data pin around itself.

On the memory side the block holds a program address counter and presents a 12-bit word to be written. It also reads a 12-bit word that a memory array returns for the current address. A level output stays high for the duration of one programming pulse, which the host opens with one command and closes with another. The array itself, entry into programming mode and the host-side spacing between commands lie outside this block.

Top module: `serprog_slave`

## Requirements
- R1: After reset, the address output is 0, the programming level is low, and the data pin is released (output enable low).
- R2: The block assembles a command from 6 bits. It latches each bit on a falling edge of the programming clock, least significant bit first. The codes, written MSB to LSB, are: write-word 000010, fetch-word 000100, advance-address 000110, start-pulse 001000 and stop-pulse 001110.
- R3: After write-word, a frame of 16 clock cycles follows. Cycle 1 is a start bit and cycle 16 is a stop bit. Cycles 2 to 15 carry a 14-bit word, LSB first, latched on falling edges. The write-word output takes the low 12 bits of that word and discards bits 12 and 13.
- R4: After fetch-word, the block drives the word at the current address onto the data pin, LSB first. Output enable goes high at the 2nd rising edge of the frame and drops at the 16th. Frame bits 12 and 13 are driven as 0. Outside this window the pin is not driven.
- R5: Advance-address increments the address output by exactly one. No other command changes the address.
- R6: Start-pulse raises the programming level only when a write-word frame has completed since the previous pulse began. Otherwise the block ignores it. The level stays high until stop-pulse is decoded.
- R7: While the programming level is high, the block ignores every command except stop-pulse. It starts no frame and leaves the address unchanged.
- R8: A 6-bit code outside the five defined ones has no effect and starts no data frame. The next 6 bits are decoded as a fresh command.
- R9: The block completes a command's effect (level change, address step or frame arm) within 8 system clock cycles of the command's last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_i | input | 1 | Host programming clock (asynchronous) |
| pdat_i | input | 1 | Data pin, input side |
| pdat_o | output | 1 | Data pin, output value |
| pdat_oe | output | 1 | Data pin output enable |
| mem_addr | output | AW | Program address counter |
| mem_wdata | output | DW | Word to be written |
| mem_prog | output | 1 | Programming pulse active |
| mem_rdata | input | DW | Word read at mem_addr |

## Verification
The assertions assume a programming clock whose high and low phases each last several system clock cycles. They also assume that the data pin is stable around each falling edge, so that the synchronized clock and data stay aligned. The bench holds every half-period of the programming clock for 8 system cycles and changes the data pin only together with a rising edge. It sends a data frame only after a command that the bench's own model expects to be accepted. Random sequences of all five commands and undefined codes mix with directed cases: a start-pulse with no write before it, a second start-pulse after a stop, commands issued during a pulse, and upper data bits set to 1.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam int CMD_W = 6;

  localparam logic [CMD_W-1:0] OP_WRITE = 6'b000010;
  localparam logic [CMD_W-1:0] OP_FETCH = 6'b000100;
  localparam logic [CMD_W-1:0] OP_ADV   = 6'b000110;
  localparam logic [CMD_W-1:0] OP_START = 6'b001000;
  localparam logic [CMD_W-1:0] OP_STOP  = 6'b001110;

  typedef enum logic [1:0] {
    F_IDLE  = 2'd0,
    F_WRITE = 2'd1,
    F_FETCH = 2'd2
  } frame_mode_e;
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic lvl_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], async_i};
  end

  assign lvl_o = chain[STAGES-1];
endmodule

// File: rtl/serprog_cmd.sv
module serprog_cmd import serprog_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pc_fall,
  input  logic             din,
  output logic             stb,
  output logic [CMD_W-1:0] code
);
  localparam int BW = $clog2(CMD_W);

  logic [CMD_W-1:0] sh;
  logic [BW-1:0]    cnt;
  logic [CMD_W-1:0] sh_nxt;

  assign sh_nxt = {din, sh[CMD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      cnt  <= '0;
      stb  <= 1'b0;
      code <= '0;
    end else begin
      stb <= 1'b0;
      if (en && pc_fall) begin
        sh <= sh_nxt;
        if (cnt == BW'(CMD_W-1)) begin
          cnt  <= '0;
          stb  <= 1'b1;
          code <= sh_nxt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);
endmodule

// File: rtl/serprog_frame.sv
module serprog_frame import serprog_pkg::*; #(
  parameter int DW = 12,
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_write,
  input  logic          start_fetch,
  input  logic          pc_rise,
  input  logic          pc_fall,
  input  logic          din,
  input  logic [DW-1:0] rdata,
  output logic          busy,
  output logic          write_done,
  output logic [DW-1:0] wdata,
  output logic          dout,
  output logic          oe
);
  localparam int FRAME = FW + 2;
  localparam int CW    = $clog2(FRAME + 1);

  frame_mode_e   mode;
  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;
  logic [FW-1:0] sh;
  logic          in_window;

  assign nxt       = cnt + 1'b1;
  assign in_window = (nxt >= CW'(2)) && (nxt <= CW'(FRAME-1));
  assign busy      = (mode != F_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= F_IDLE;
      cnt        <= '0;
      sh         <= '0;
      wdata      <= '0;
      dout       <= 1'b0;
      oe         <= 1'b0;
      write_done <= 1'b0;
    end else begin
      write_done <= 1'b0;
      case (mode)
        F_IDLE: begin
          cnt <= '0;
          if (start_write) begin
            mode <= F_WRITE;
          end else if (start_fetch) begin
            mode <= F_FETCH;
            sh   <= FW'(rdata);
          end
        end
        F_WRITE: begin
          if (pc_rise) cnt <= nxt;
          if (pc_fall) begin
            if (cnt >= CW'(2) && cnt <= CW'(FRAME-1))
              sh <= {din, sh[FW-1:1]};
            if (cnt == CW'(FRAME)) begin
              mode       <= F_IDLE;
              wdata      <= sh[DW-1:0];
              write_done <= 1'b1;
            end
          end
        end
        F_FETCH: begin
          if (pc_rise) begin
            cnt <= nxt;
            if (in_window) begin
              oe   <= 1'b1;
              dout <= sh[0];
              sh   <= {1'b0, sh[FW-1:1]};
            end else begin
              oe   <= 1'b0;
              dout <= 1'b0;
            end
          end
          if (pc_fall && cnt == CW'(FRAME)) mode <= F_IDLE;
        end
        default: mode <= F_IDLE;
      endcase
    end
  end

  // R4
  oe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    oe |-> (mode == F_FETCH));

  // R3
  wdata_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wdata) |-> write_done);
endmodule

// File: rtl/serprog_addr.sv
module serprog_addr #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)      addr <= '0;
    else if (inc) addr <= addr + 1'b1;
  end

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr) |-> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/serprog_slave.sv
module serprog_slave import serprog_pkg::*; #(
  parameter int AW   = 13,
  parameter int DW   = 12,
  parameter int FW   = 14,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pclk_i,
  input  logic          pdat_i,
  output logic          pdat_o,
  output logic          pdat_oe,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_prog,
  input  logic [DW-1:0] mem_rdata
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_lvl;
  logic            clk_prev;
  logic            pc_rise, pc_fall;
  logic            cmd_stb;
  logic [CMD_W-1:0] cmd_code;
  logic            frame_busy, write_done;
  logic            armed;
  logic            go_write, go_fetch, go_adv, go_start, go_stop;

  assign pin_raw = {pdat_i, pclk_i};

  for (genvar gi = 0; gi < NPIN; gi++) begin : g_sync
    serprog_sync #(.STAGES(SYNC)) u_sync (
      .clk(clk), .rst(rst), .async_i(pin_raw[gi]), .lvl_o(pin_lvl[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) clk_prev <= 1'b0;
    else     clk_prev <= pin_lvl[0];
  end

  assign pc_rise = pin_lvl[0] & ~clk_prev;
  assign pc_fall = ~pin_lvl[0] & clk_prev;

  serprog_cmd u_cmd (
    .clk(clk), .rst(rst), .en(~frame_busy), .pc_fall(pc_fall),
    .din(pin_lvl[1]), .stb(cmd_stb), .code(cmd_code)
  );

  assign go_stop  = cmd_stb && (cmd_code == OP_STOP);
  assign go_write = cmd_stb && !mem_prog && (cmd_code == OP_WRITE);
  assign go_fetch = cmd_stb && !mem_prog && (cmd_code == OP_FETCH);
  assign go_adv   = cmd_stb && !mem_prog && (cmd_code == OP_ADV);
  assign go_start = cmd_stb && !mem_prog && (cmd_code == OP_START) && armed;

  serprog_frame #(.DW(DW), .FW(FW)) u_frame (
    .clk(clk), .rst(rst), .start_write(go_write), .start_fetch(go_fetch),
    .pc_rise(pc_rise), .pc_fall(pc_fall), .din(pin_lvl[1]),
    .rdata(mem_rdata), .busy(frame_busy), .write_done(write_done),
    .wdata(mem_wdata), .dout(pdat_o), .oe(pdat_oe)
  );

  serprog_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .inc(go_adv), .addr(mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_prog <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (write_done) armed <= 1'b1;
      else if (go_start) armed <= 1'b0;
      if (go_stop) mem_prog <= 1'b0;
      else if (go_start) mem_prog <= 1'b1;
    end
  end

  // R6
  prog_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_prog) |-> $past(armed));

  // R7
  prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_prog && !(cmd_stb && cmd_code == OP_STOP)) |=> mem_prog);

  // R7
  prog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mem_prog |-> !frame_busy);
endmodule

// File: tb/sim_serprog_slave.sv
module sim_serprog_slave;
  localparam int CLK_NS = 10;
  localparam int HALF   = 8;
  localparam int AW     = 13;
  localparam int DW     = 12;

  logic          clk = 1'b0, rst = 1'b1, pclk = 1'b0, pdat = 1'b0;
  logic          pdat_o, pdat_oe, mem_prog;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  bit            m_prog, m_armed;

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return DW'((32'(a) * 37 + 32'h5a5) & 32'hfff);
  endfunction

  assign mem_rdata = word_at(mem_addr);

  serprog_slave u0 (
    .clk(clk), .rst(rst), .pclk_i(pclk), .pdat_i(pdat), .pdat_o(pdat_o),
    .pdat_oe(pdat_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_prog(mem_prog), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pcycle(input logic b, output logic ob, output logic ooe);
    pdat = b;
    pclk = 1'b1;
    repeat (HALF) @(negedge clk);
    ob  = pdat_o;
    ooe = pdat_oe;
    pclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    logic ob, ooe;
    for (int i = 0; i < 6; i++) pcycle(c[i], ob, ooe);
  endtask

  task automatic write_frame(input logic [13:0] w);
    logic ob, ooe;
    bit oe_seen = 0;
    pcycle(1'b0, ob, ooe); oe_seen |= ooe;
    for (int i = 0; i < 14; i++) begin pcycle(w[i], ob, ooe); oe_seen |= ooe; end
    pcycle(1'b0, ob, ooe); oe_seen |= ooe;
    chk(!oe_seen, "R3 pin stays input in write frame", int'(oe_seen), 0);
  endtask

  task automatic fetch_frame(input logic [DW-1:0] exp);
    logic ob, ooe;
    logic [13:0] got = '0;
    bit oe_bad = 0;
    pcycle(1'b0, ob, ooe); if (ooe) oe_bad = 1;
    for (int i = 0; i < 14; i++) begin
      pcycle(1'b0, ob, ooe);
      if (!ooe) oe_bad = 1;
      got[i] = ob;
    end
    pcycle(1'b0, ob, ooe); if (ooe) oe_bad = 1;
    chk(got == {2'b00, exp}, "R4 fetched word", int'(got), int'({2'b00, exp}));
    chk(!oe_bad, "R4 output enable window", int'(oe_bad), 0);
  endtask

  task automatic check_state(input string tag);
    chk(mem_addr == m_addr, {tag, " R5 address"}, int'(mem_addr), int'(m_addr));
    chk(mem_prog == m_prog, {tag, " R6 programming level"}, int'(mem_prog), int'(m_prog));
    chk(pdat_oe == 1'b0, {tag, " R4 pin released"}, int'(pdat_oe), 0);
  endtask

  task automatic op_write(input logic [13:0] w);
    send_cmd(6'b000010);
    if (!m_prog) begin
      write_frame(w);
      m_wdata = w[11:0];
      m_armed = 1;
      chk(mem_wdata == m_wdata, "R3 write word low 12 bits", int'(mem_wdata), int'(m_wdata));
    end
    check_state("write");
  endtask

  task automatic op_fetch;
    send_cmd(6'b000100);
    if (!m_prog) fetch_frame(word_at(m_addr));
    check_state("fetch");
  endtask

  task automatic op_adv;
    send_cmd(6'b000110);
    if (!m_prog) m_addr = m_addr + 1'b1;
    check_state("R7 advance");
  endtask

  task automatic op_start;
    send_cmd(6'b001000);
    if (!m_prog && m_armed) begin m_prog = 1; m_armed = 0; end
    check_state("R9 start");
  endtask

  task automatic op_stop;
    send_cmd(6'b001110);
    m_prog = 0;
    check_state("R9 stop");
  endtask

  function automatic bit defined(input logic [5:0] c);
    return c == 6'h02 || c == 6'h04 || c == 6'h06 || c == 6'h08 || c == 6'h0e;
  endfunction

  task automatic op_undef(input logic [5:0] c);
    send_cmd(c);
    check_state("R8 undefined");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7715));
    m_addr = '0; m_wdata = '0; m_prog = 0; m_armed = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(mem_addr == '0, "R1 address after reset", int'(mem_addr), 0);
    chk(mem_prog == 1'b0, "R1 level after reset", int'(mem_prog), 0);
    chk(pdat_oe == 1'b0, "R1 pin after reset", int'(pdat_oe), 0);

    // R6 start without prior write is ignored
    op_start();
    // R2 R3 upper bits discarded
    op_write(14'h3abc);
    op_fetch();
    op_adv();
    op_adv();
    op_fetch();
    // R8 undefined codes, then normal command decodes cleanly
    op_undef(6'b111111);
    op_undef(6'b000001);
    op_adv();
    // R6 R7 pulse, commands ignored during it
    op_start();
    op_adv();
    op_write(14'h1234);
    op_fetch();
    op_start();
    op_stop();
    // R6 second start needs a new write
    op_start();
    op_write(14'h0fff);
    op_start();
    op_stop();

    for (int n = 0; n < 50; n++) begin
      int sel = $urandom_range(0, 5);
      case (sel)
        0: op_write(14'($urandom));
        1: op_fetch();
        2: op_adv();
        3: op_start();
        4: op_stop();
        default: begin
          logic [5:0] c = 6'($urandom);
          while (defined(c)) c = 6'($urandom);
          op_undef(c);
        end
      endcase
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule